// File: doc/BRIEF.md
# Self-Correcting Decade Ring Counter

This block is a five-stage twisted-ring (Johnson) counter that steps through ten legal states and presents them as ten one-hot, active-high decoded lines plus an active-low carry taken from the last ring stage. Two count-request inputs of opposite polarity are provided. `cnt_up` requests a step on its rising edge and `cnt_dn_n` requests one on its falling edge. Each input acts as an enable for the other, so either one can serve as the count clock while the other gates it.

The design is fully synchronous to `clk`. Both request inputs pass through synchronizers, and their edges are found by comparing each synchronized level with the value from the previous cycle. An active-high `clear` forces state zero asynchronously. Its release is synchronized to `clk`. The steering logic on one inner ring stage collapses any illegal ring pattern into the legal sequence within a bounded number of steps.

A test-only parallel load port lets verification place arbitrary ring patterns, including illegal ones, into the counter. The carry output is low during the upper half of the count, so it can feed the `cnt_up` input of a following counter to extend the range.

Top module: `decade_johnson_counter`

## Requirements
- R1: While `clear` is high the counter is in state zero: `dec` = 10'b0000000001 and `carry_n` = 1. This takes effect without waiting for a `clk` edge and holds whatever the count inputs do.
- R2: A rising edge on `cnt_up` while `cnt_dn_n` is low advances the count by one.
- R3: A falling edge on `cnt_dn_n` while `cnt_up` is high advances the count by one.
- R4: No other input activity changes the state. This covers a rising `cnt_up` while `cnt_dn_n` is high, a falling `cnt_dn_n` while `cnt_up` is low, either input falling/rising in its non-counting direction, and steady levels.
- R5: In state k (0..9) only `dec[k]` is high. Successive advances visit 0,1,...,9 and then wrap to 0.
- R6: `carry_n` is low exactly in states 5 through 9 and high in states 0 through 4.
- R7: Consider `cnt_up` used as the clock with `cnt_dn_n` high as an inhibit. Pulses on `cnt_up` are ignored. Then, if `cnt_dn_n` falls while `cnt_up` is already high, that transition causes exactly one extra advance.
- R8: At most one advance occurs per `clk` cycle. If `cnt_up` rises and `cnt_dn_n` falls in the same cycle, the state advances by exactly one.
- R9: With the default two synchronizer stages, an input change made between clock edges appears on `dec` after the third following rising edge of `clk` and not earlier.
- R10: From each of the 22 illegal ring patterns, the counter shows a legal one-hot state after at most 11 advances. From then on it counts normally.
- R11: When `test_load` is high at a rising `clk` edge, the ring takes `test_ring` and any advance in that cycle is discarded. Bit i of `test_ring` is ring stage i. Legal state k is the pattern with stages 0..k-1 set for k ≤ 5, and the pattern with stages k-5..4 set for k > 5.
- R12: A counting condition already present on the inputs when `clear` is released does not produce an advance. The counter stays in state zero until a fresh qualifying edge arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clear | input | 1 | Master reset, active high, asynchronous assert |
| cnt_up | input | 1 | Count request, rising-edge active, enabled by low `cnt_dn_n` |
| cnt_dn_n | input | 1 | Count request, falling-edge active, enabled by high `cnt_up` |
| test_load | input | 1 | Test-only parallel load strobe |
| test_ring | input | 5 | Test-only ring pattern, bit i to stage i |
| dec | output | 10 | One-hot decoded state |
| carry_n | output | 1 | Active-low carry, low in states 5 to 9 |

## Verification
The hardest situation to reach from the ports is an illegal ring pattern. Normal counting and reset can never produce one, so the correction path would otherwise go unexercised. The bench computes the ten legal patterns, takes every other 5-bit value as illegal, and forces each one through the test load port. It then issues single `cnt_up` pulses and counts how many pass before `dec` becomes one-hot, and confirms that the next pulse steps to the following state. The extra-count case of R7 and the simultaneous-edge case of R8 are produced by placing both input changes on the same clock boundary.

// File: rtl/decade_pkg.sv
package decade_pkg;
  localparam int RING_W      = 5;
  localparam int N_STATES    = 2 * RING_W;
  localparam int IDX_W       = $clog2(N_STATES + 1);
  localparam int CORR_STAGE  = 2;
  localparam int RECOVER_MAX = 11;

  typedef logic [RING_W-1:0]   ring_t;
  typedef logic [N_STATES-1:0] dec_t;

  // Ring pattern of legal state k: fill from stage 0, then drain from stage 0.
  function automatic ring_t state_pattern(input int k);
    ring_t p;
    for (int i = 0; i < RING_W; i++) begin
      p[i] = (k <= RING_W) ? (i < k) : (i >= k - RING_W);
    end
    return p;
  endfunction

  // Index of a legal pattern, or N_STATES for an illegal one.
  function automatic logic [IDX_W-1:0] ring_index(input ring_t r);
    logic [IDX_W-1:0] res;
    res = IDX_W'(N_STATES);
    for (int k = 0; k < N_STATES; k++) begin
      if (r == state_pattern(k)) res = IDX_W'(k);
    end
    return res;
  endfunction
endpackage

// File: rtl/decade_rst_sync.sv
module decade_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic clear,
  output logic rst_n
);
  logic [DEPTH-1:0] pipe_q;
  logic [DEPTH-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or posedge clear) begin
    if (clear) pipe_q <= '0;
    else       pipe_q <= pipe_d;
  end

  assign rst_n = pipe_q[DEPTH-1];
endmodule

// File: rtl/decade_in_sync.sv
module decade_in_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic prev
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {STAGES{RST_VAL}};
      prev_q <= RST_VAL;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl  = sync_q[STAGES-1];
  assign prev = prev_q;
endmodule

// File: rtl/decade_step_ctrl.sv
module decade_step_ctrl #(
  parameter int BLANK = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_lvl,
  input  logic up_prev,
  input  logic dn_lvl,
  input  logic dn_prev,
  output logic adv
);
  localparam int CW = $clog2(BLANK + 1);

  logic [CW-1:0] wait_q;
  logic [CW-1:0] wait_d;
  logic          armed;
  logic          up_fire;
  logic          dn_fire;

  assign armed = (wait_q == CW'(BLANK));

  always_comb begin
    wait_d = armed ? wait_q : wait_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_q <= '0;
    else        wait_q <= wait_d;
  end

  // Rising first input with second low, or falling second input with first high.
  always_comb begin
    up_fire = up_lvl & ~up_prev & ~dn_lvl;
    dn_fire = ~dn_lvl & dn_prev & up_lvl;
    adv     = armed & (up_fire | dn_fire);
  end

  // With both inputs steady no advance may be requested.
  assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((up_lvl == up_prev) && (dn_lvl == dn_prev)) |-> !adv);

  // After release, stale levels cannot request an advance while blanking.
  assert_blank_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !adv);
endmodule

// File: rtl/decade_ring.sv
module decade_ring
  import decade_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  load,
  input  ring_t load_val,
  output ring_t q
);
  ring_t q_r;
  ring_t shift_d;
  ring_t q_d;

  // Twisted shift; one inner stage is gated to break up extra runs of ones.
  for (genvar i = 0; i < RING_W; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign shift_d[i] = ~q_r[RING_W-1];
    end else if (i == CORR_STAGE) begin : g_fix
      assign shift_d[i] = q_r[i-1] & (q_r[i-2] | q_r[i]);
    end else begin : g_plain
      assign shift_d[i] = q_r[i-1];
    end
  end

  always_comb begin
    if (load)     q_d = load_val;
    else if (adv) q_d = shift_d;
    else          q_d = q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_d;
  end

  assign q = q_r;

  // Checker state: position in the sequence and advances spent while illegal.
  logic [IDX_W-1:0] cur_idx;
  logic             cur_legal;
  logic [3:0]       stray_q;

  assign cur_idx   = ring_index(q_r);
  assign cur_legal = (cur_idx < IDX_W'(N_STATES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       stray_q <= '0;
    else if (load || cur_legal)       stray_q <= '0;
    else if (adv && stray_q != 4'hF)  stray_q <= stray_q + 1'b1;
  end

  assert_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (q_r == '0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !load) |=> $stable(q_r));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load && cur_legal) |=>
      (cur_idx == (($past(cur_idx) == IDX_W'(N_STATES - 1)) ? '0 : $past(cur_idx) + 1'b1)));

  assert_recover_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_legal |-> (stray_q < 4'(RECOVER_MAX)));

  assert_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q_r == $past(load_val)));
endmodule

// File: rtl/decade_johnson_counter.sv
module decade_johnson_counter
  import decade_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              clear,
  input  logic              cnt_up,
  input  logic              cnt_dn_n,
  input  logic              test_load,
  input  logic [RING_W-1:0] test_ring,
  output logic [N_STATES-1:0] dec,
  output logic              carry_n
);
  localparam int BLANK = SYNC_STAGES + 1;

  logic  rst_n;
  logic  up_lvl, up_prev, dn_lvl, dn_prev;
  logic  adv;
  ring_t ring_q;

  decade_rst_sync #(.DEPTH(RST_STAGES)) i_rst (
    .clk   (clk),
    .clear (clear),
    .rst_n (rst_n)
  );

  decade_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_up (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cnt_up),
    .lvl   (up_lvl),
    .prev  (up_prev)
  );

  decade_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_dn (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cnt_dn_n),
    .lvl   (dn_lvl),
    .prev  (dn_prev)
  );

  decade_step_ctrl #(.BLANK(BLANK)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .up_lvl  (up_lvl),
    .up_prev (up_prev),
    .dn_lvl  (dn_lvl),
    .dn_prev (dn_prev),
    .adv     (adv)
  );

  decade_ring i_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .load     (test_load),
    .load_val (test_ring),
    .q        (ring_q)
  );

  // Each line looks at two neighbouring stages only, so one line moves per step.
  for (genvar k = 0; k < N_STATES; k++) begin : g_dec
    if (k == 0) begin : g_first
      assign dec[k] = ~ring_q[RING_W-1] & ~ring_q[0];
    end else if (k < RING_W) begin : g_fill
      assign dec[k] = ring_q[k-1] & ~ring_q[k];
    end else if (k == RING_W) begin : g_full
      assign dec[k] = ring_q[RING_W-1] & ring_q[0];
    end else begin : g_drain
      assign dec[k] = ~ring_q[k-RING_W-1] & ring_q[k-RING_W];
    end
  end

  assign carry_n = ~ring_q[RING_W-1];

  logic ring_legal;
  assign ring_legal = (ring_index(ring_q) < IDX_W'(N_STATES));

  assert_onehot_R5: assert property (@(posedge clk) disable iff (clear)
    ring_legal |-> $onehot(dec));

  assert_carry_R6: assert property (@(posedge clk) disable iff (clear)
    ring_legal |-> (carry_n == ~|dec[N_STATES-1:RING_W]));
endmodule

// File: tb/test_decade_johnson_counter.sv
module test_decade_johnson_counter;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       clear;
  logic       cnt_up;
  logic       cnt_dn_n;
  logic       test_load;
  logic [4:0] test_ring;
  logic [9:0] dec;
  logic       carry_n;

  int total = 0;
  int bad   = 0;
  int exp_st = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;

  decade_johnson_counter i_decade_johnson_counter (
    .clk       (clk),
    .clear     (clear),
    .cnt_up    (cnt_up),
    .cnt_dn_n  (cnt_dn_n),
    .test_load (test_load),
    .test_ring (test_ring),
    .dec       (dec),
    .carry_n   (carry_n)
  );

  function automatic logic [4:0] pat(input int k);
    if (k <= 5) return 5'((1 << k) - 1);
    return 5'(~((1 << (k - 5)) - 1));
  endfunction

  function automatic bit is_legal(input logic [4:0] p);
    for (int k = 0; k < 10; k++) if (pat(k) == p) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int idx_of(input logic [9:0] v);
    int n = 0;
    int at = -1;
    for (int k = 0; k < 10; k++) if (v[k]) begin n++; at = k; end
    return (n == 1) ? at : -1;
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chk_state(input string req, input int k);
    chk({req, " dec"}, int'(dec), 1 << k);
    chk({req, " carry_n"}, int'(carry_n), (k >= 5) ? 0 : 1);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic set_in(input logic u, input logic d);
    @(negedge clk);
    cnt_up   = u;
    cnt_dn_n = d;
    settle();
  endtask

  task automatic pulse_up();
    set_in(1'b1, cnt_dn_n);
    set_in(1'b0, cnt_dn_n);
  endtask

  task automatic t_reset_R1();
    chk_state("R1 after power-up clear", 0);
    set_in(1'b0, 1'b0);
    repeat (3) pulse_up();
    exp_st = 3;
    chk_state("R2 before clear", 3);
    @(posedge clk);
    #2 clear = 1'b1;
    #1 chk_state("R1 async clear", 0);
    pulse_up();
    chk_state("R1 inputs ignored in clear", 0);
    @(negedge clk) clear = 1'b0;
    repeat (8) @(negedge clk);
    exp_st = 0;
    chk_state("R1 after release", 0);
  endtask

  task automatic t_up_R2();
    for (int n = 0; n < 23; n++) begin
      pulse_up();
      exp_st = (exp_st + 1) % 10;
      chk_state("R2 R5 R6 up count", exp_st);
    end
  endtask

  task automatic t_dn_R3();
    set_in(1'b0, 1'b1);
    chk_state("R4 dn rise up low", exp_st);
    set_in(1'b1, 1'b1);
    chk_state("R4 up rise dn high", exp_st);
    for (int n = 0; n < 12; n++) begin
      set_in(1'b1, 1'b0);
      exp_st = (exp_st + 1) % 10;
      chk_state("R3 dn fall up high", exp_st);
      set_in(1'b1, 1'b1);
      chk_state("R4 dn rise", exp_st);
    end
  endtask

  task automatic t_idle_R4();
    set_in(1'b0, 1'b1);
    chk_state("R4 up fall", exp_st);
    set_in(1'b0, 1'b0);
    chk_state("R4 dn fall up low", exp_st);
    set_in(1'b0, 1'b1);
    repeat (20) @(negedge clk);
    chk_state("R4 steady levels", exp_st);
  endtask

  task automatic t_extra_R7();
    pulse_up();
    pulse_up();
    chk_state("R7 inhibited pulses", exp_st);
    set_in(1'b1, 1'b1);
    chk_state("R7 up high inhibited", exp_st);
    set_in(1'b1, 1'b0);
    exp_st = (exp_st + 1) % 10;
    chk_state("R7 extra count on enable", exp_st);
    set_in(1'b0, 1'b0);
    chk_state("R7 up fall", exp_st);
    set_in(1'b1, 1'b0);
    exp_st = (exp_st + 1) % 10;
    chk_state("R7 normal clocking resumes", exp_st);
  endtask

  task automatic t_both_R8();
    set_in(1'b0, 1'b1);
    chk_state("R8 opposite directions", exp_st);
    set_in(1'b1, 1'b0);
    exp_st = (exp_st + 1) % 10;
    chk_state("R8 both edges one step", exp_st);
  endtask

  task automatic t_latency_R9();
    set_in(1'b0, 1'b0);
    @(negedge clk) cnt_up = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk_state("R9 no change after two edges", exp_st);
    @(negedge clk);
    exp_st = (exp_st + 1) % 10;
    chk_state("R9 change after third edge", exp_st);
    set_in(1'b0, 1'b0);
  endtask

  task automatic t_load_R11();
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      test_load = 1'b1;
      test_ring = pat(k);
      @(negedge clk) test_load = 1'b0;
      chk_state("R11 load legal", k);
    end
    @(negedge clk) cnt_up = 1'b1;
    @(negedge clk);
    @(negedge clk);
    test_load = 1'b1;
    test_ring = pat(4);
    @(negedge clk) test_load = 1'b0;
    settle();
    exp_st = 4;
    chk_state("R11 load beats advance", exp_st);
    set_in(1'b0, 1'b0);
  endtask

  task automatic t_recover_R10();
    for (int p = 0; p < 32; p++) begin
      if (!is_legal(5'(p))) begin
        int n = 0;
        int at;
        @(negedge clk);
        test_load = 1'b1;
        test_ring = 5'(p);
        @(negedge clk) test_load = 1'b0;
        chk("R10 illegal not one-hot", idx_of(dec), -1);
        while (idx_of(dec) < 0 && n < 12) begin
          pulse_up();
          n++;
        end
        chk("R10 recovered within 11", (n <= 11) ? 1 : 0, 1);
        at = idx_of(dec);
        if (at >= 0) begin
          pulse_up();
          exp_st = (at + 1) % 10;
          chk_state("R10 counts after recovery", exp_st);
        end
      end
    end
  endtask

  task automatic t_blank_R12();
    @(negedge clk) clear = 1'b1;
    set_in(1'b0, 1'b0);
    set_in(1'b1, 1'b0);
    @(negedge clk) clear = 1'b0;
    repeat (10) @(negedge clk);
    exp_st = 0;
    chk_state("R12 held level no step", 0);
    set_in(1'b0, 1'b0);
    pulse_up();
    exp_st = 1;
    chk_state("R12 fresh edge counts", 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clear     = 1'b1;
    cnt_up    = 1'b0;
    cnt_dn_n  = 1'b0;
    test_load = 1'b0;
    test_ring = '0;
    repeat (4) @(negedge clk);
    clear = 1'b0;
    repeat (8) @(negedge clk);
    t_reset_R1();
    t_up_R2();
    t_dn_R3();
    t_idle_R4();
    t_extra_R7();
    t_both_R8();
    t_latency_R9();
    t_load_R11();
    t_recover_R10();
    t_blank_R12();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule